// File: doc/BRIEF.md
# Masked-Write Configuration Register Bank with Line-State Change Interrupt

This block holds a small set of 16-bit configuration registers behind a single-cycle register bus. Every write word carries its own per-bit write enables: the upper half of the 32-bit word selects which bits of the lower half are written. Software can therefore change one bit or one multi-bit field without reading the register first. Bits that are not enabled keep their value, so two agents changing different fields of the same register do not disturb each other.

Alongside the configuration registers sits a detection group that watches a 2-bit line-state input from the transceiver. The input is synchronized, and any change in its value while detection is armed latches a status flag. The registered interrupt output is high while both the flag and the arm bit are set. A service routine first disarms detection and then writes the clear control. All three controls (arm, flag, clear) use the same masked-write convention as the configuration registers.

Address map with default parameters: configuration registers at 0 to NUM_CFG-1 (0 to 3), arm register at NUM_CFG (4), flag register at NUM_CFG+1 (5), clear register at NUM_CFG+2 (6). Every other address is unmapped. The bus has no back-pressure. A request is accepted in the cycle `req_valid` is high. Read data is returned in the following cycle together with `rd_valid`.

Top module: `regbank_top`

## Requirements
- R1: A write to a configuration register replaces bit n (n = 0..15) of the register with `req_wdata[n]` only when `req_wdata[16+n]` is 1. All other bits keep their previous value.
- R2: A read request returns, one cycle later with `rd_valid` high, the 16 stored bits in `rd_data[15:0]` and zero in `rd_data[31:16]`.
- R3: A multi-bit field is written by placing its value at the field's lowest bit position and setting the enable bits of exactly that field's span. Bits outside the span are unchanged.
- R4: After reset, every configuration register, the arm bit and the flag read zero, and `irq` is 0.
- R5: With the arm bit (bit 0 of address NUM_CFG) set, any change of `line_state` sets the flag (bit 0 of address NUM_CFG+1) three clock edges after the change, counting two synchronizer stages and one compare stage.
- R6: A change of `line_state` while the arm bit is 0 leaves the flag at 0.
- R7: A write to address NUM_CFG+2 with `req_wdata[16]`=1 and `req_wdata[0]`=1 clears the flag. The same write with `req_wdata[16]`=0 has no effect. This address reads as zero.
- R8: When a flag set and a clear write fall in the same cycle, the flag ends up set.
- R9: `irq` is high in the cycle after one in which both the flag and the arm bit are 1, and low otherwise. Disarming drops `irq` while the flag is kept.
- R10: Writes to the flag address do not change the flag. Writes to unmapped addresses change no register, and reads from them return zero.
- R11: `cfg_out` bits [16*k+15:16*k] equal configuration register k from the edge on which it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| req_valid | input | 1 | Bus request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 32 | Upper half: bit enables; lower half: data |
| rd_valid | output | 1 | Read data valid (cycle after a read request) |
| rd_data | output | 32 | Read data, upper half zero |
| line_state | input | LS_W | Asynchronous line-state input |
| cfg_out | output | 16*NUM_CFG | Configuration register contents |
| irq | output | 1 | Registered interrupt: flag AND arm |

## Verification
A corrupted merge of enable bits and data shows up in `cfg_out` on the edge after the write, and in `rd_data` one cycle after the next read. The bench therefore compares every random write against a model of the register file. A wrong flag, such as a lost set, a missed clear or the wrong priority when set and clear coincide, is visible on a read of the flag address and on `irq` one cycle later. The bench checks the flag after a fixed wait that covers the synchronizer latency. A faulty synchronizer or compare stage appears as a missing or spurious flag within four cycles of a line change.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  // merge the data half into the old value under the enable half
  function automatic half_t apply_bit_enables(half_t old_val, word_t wword);
    half_t en_bits;
    half_t dat_bits;
    en_bits  = wword[WORD_W-1:HALF_W];
    dat_bits = wword[HALF_W-1:0];
    return (old_val & ~en_bits) | (dat_bits & en_bits);
  endfunction
endpackage

// File: rtl/mask_reg.sv
module mask_reg
  import regbank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wr_word,
  output half_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (wr_en)
      q <= apply_bit_enables(q, wr_word);
  end
endmodule

// File: rtl/ls_detect.sv
module ls_detect #(
  parameter int LS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LS_W-1:0] ls_async,
  input  logic            arm,
  input  logic            clr,
  output logic            chg,
  output logic            flag,
  output logic            irq
);
  logic [LS_W-1:0] stage [SYNC_STAGES];
  logic [LS_W-1:0] prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= ls_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage[SYNC_STAGES-1];
  end

  assign chg = (stage[SYNC_STAGES-1] != prev_q);

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             flag <= 1'b0;
    else if (chg && arm)    flag <= 1'b1;
    else if (clr)           flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= flag & arm;
  end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter int ADDR_W  = 4,
  parameter int LS_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [31:0]               req_wdata,
  output logic                      rd_valid,
  output logic [31:0]               rd_data,
  input  logic [LS_W-1:0]           line_state,
  output logic [HALF_W*NUM_CFG-1:0] cfg_out,
  output logic                      irq
);
  localparam logic [ADDR_W-1:0] ADR_ARM  = ADDR_W'(NUM_CFG);
  localparam logic [ADDR_W-1:0] ADR_FLAG = ADDR_W'(NUM_CFG + 1);
  localparam logic [ADDR_W-1:0] ADR_CLR  = ADDR_W'(NUM_CFG + 2);

  half_t cfg_q [NUM_CFG];
  logic  wr_go;
  logic  rd_go;
  logic  arm_q;
  logic  clr_pulse;
  logic  ls_chg;
  logic  flag_q;
  word_t rd_next;

  assign wr_go = req_valid & req_write;
  assign rd_go = req_valid & ~req_write;

  generate
    for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
      mask_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_go && (req_addr == ADDR_W'(k))),
        .wr_word(req_wdata),
        .q      (cfg_q[k])
      );
      assign cfg_out[HALF_W*k +: HALF_W] = cfg_q[k];
    end
  endgenerate

  // arm bit: bit 0, gated by its enable bit 16
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      arm_q <= 1'b0;
    else if (wr_go && req_addr == ADR_ARM && req_wdata[HALF_W])
      arm_q <= req_wdata[0];
  end

  assign clr_pulse = wr_go && (req_addr == ADR_CLR) && req_wdata[HALF_W] && req_wdata[0];

  ls_detect #(.LS_W(LS_W), .SYNC_STAGES(2)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .ls_async(line_state),
    .arm     (arm_q),
    .clr     (clr_pulse),
    .chg     (ls_chg),
    .flag    (flag_q),
    .irq     (irq)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (req_addr == ADDR_W'(i)) rd_next[HALF_W-1:0] = cfg_q[i];
    if (req_addr == ADR_ARM)  rd_next[0] = arm_q;
    if (req_addr == ADR_FLAG) rd_next[0] = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_go;
      rd_data  <= rd_go ? rd_next : '0;
    end
  end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int CFG_BITS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [31:0]         req_wdata,
  input logic [CFG_BITS-1:0] cfg_out,
  input logic                chg,
  input logic                arm,
  input logic                clr,
  input logic                flag,
  input logic                irq
);
  // R1
  zero_enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_wdata[31:16] == 16'h0) |=> $stable(cfg_out));

  // R6
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(chg && arm));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && arm) |=> flag);

  // R7
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(chg && arm)) |=> !flag);

  // R9
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && arm) |=> irq);

  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag && arm) |=> !irq);
endmodule

bind regbank_top regbank_chk #(.CFG_BITS(16 * NUM_CFG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_wdata(req_wdata),
  .cfg_out  (cfg_out),
  .chg      (ls_chg),
  .arm      (arm_q),
  .clr      (clr_pulse),
  .flag     (flag_q),
  .irq      (irq)
);

// File: tb/test_regbank_top.sv
module test_regbank_top;
  localparam int NUM_CFG = 4;
  localparam int ADDR_W  = 4;
  localparam int LS_W    = 2;
  localparam logic [ADDR_W-1:0] A_ARM  = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd5;
  localparam logic [ADDR_W-1:0] A_CLR  = 4'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [LS_W-1:0] line_state = '0;
  logic [16*NUM_CFG-1:0] cfg_out;
  logic irq;

  int total = 0;
  int bad = 0;
  logic [15:0] model [NUM_CFG];
  logic [31:0] rv;

  always #2 clk = ~clk;

  regbank_top #(.NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W), .LS_W(LS_W)) i_regbank_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .line_state(line_state), .cfg_out(cfg_out), .irq(irq)
  );

  function automatic logic [15:0] expect_merge(logic [15:0] old, logic [31:0] w);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) r[b] = w[16+b] ? w[b] : old[b];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (a < NUM_CFG) model[a] = expect_merge(model[a], d);
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    total++;
    if (rd_valid !== 1'b1) begin
      bad++;
      $display("FAIL R2 rd_valid actual=%b expected=1", rd_valid);
    end
    d = rd_data;
  endtask

  task automatic check_cfg(string req);
    for (int k = 0; k < NUM_CFG; k++)
      chk(req, {16'h0, cfg_out[16*k +: 16]}, {16'h0, model[k]});
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < NUM_CFG; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R4 reset state
    chk("R4 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    check_cfg("R4 cfg");
    for (int a = 0; a < 7; a++) begin
      rd(ADDR_W'(a), rv);
      chk("R4 read", rv, 32'h0);
    end

    // R1 directed
    wr(4'd0, 32'hFFFF_A5A5);
    rd(4'd0, rv); chk("R1 full", rv, 32'h0000_A5A5);
    wr(4'd0, 32'h00F0_0F0F);
    rd(4'd0, rv); chk("R1 partial", rv, 32'h0000_A505);
    chk("R11 cfg_out", {16'h0, cfg_out[15:0]}, 32'h0000_A505);

    // R3 field bits 9..7 set to 5
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd1, 32'h0380_0000 | (32'd5 << 7));
    rd(4'd1, rv); chk("R3 field", rv, 32'h0000_FEFF);

    // R1 R2 R11 random
    for (int i = 0; i < 300; i++) begin
      logic [ADDR_W-1:0] a;
      logic [31:0] d;
      a = ADDR_W'($urandom_range(0, NUM_CFG - 1));
      d = $urandom;
      if (i % 10 == 0) d[31:16] = 16'h0;
      wr(a, d);
      check_cfg("R11 random");
      a = ADDR_W'($urandom_range(0, NUM_CFG - 1));
      rd(a, rv);
      chk("R2 random read", rv, {16'h0, model[a]});
    end

    // R10 flag write and unmapped
    wr(A_FLAG, 32'hFFFF_FFFF);
    rd(A_FLAG, rv); chk("R10 flag write", rv, 32'h0);
    wr(4'd9, 32'hFFFF_1234);
    rd(4'd9, rv); chk("R10 unmapped read", rv, 32'h0);
    check_cfg("R10 unmapped write");

    // R6 change while disarmed
    line_state = 2'b01;
    wait_cycles(6);
    rd(A_FLAG, rv); chk("R6 flag", rv, 32'h0);
    chk("R6 irq", {31'h0, irq}, 32'h0);

    // R5 arm, change
    wr(A_ARM, 32'h0001_0001);
    rd(A_ARM, rv); chk("R5 arm read", rv, 32'h1);
    line_state = 2'b11;
    wait_cycles(6);
    rd(A_FLAG, rv); chk("R5 flag", rv, 32'h1);
    chk("R9 irq high", {31'h0, irq}, 32'h1);

    // R7 clear without enable bit
    wr(A_CLR, 32'h0000_0001);
    rd(A_FLAG, rv); chk("R7 no-enable clear", rv, 32'h1);
    rd(A_CLR, rv); chk("R7 clr reads zero", rv, 32'h0);

    // R9 disarm drops irq, flag kept
    wr(A_ARM, 32'h0001_0000);
    wait_cycles(1);
    chk("R9 irq low", {31'h0, irq}, 32'h0);
    rd(A_FLAG, rv); chk("R9 flag kept", rv, 32'h1);
    wr(A_CLR, 32'h0001_0001);
    rd(A_FLAG, rv); chk("R7 clear", rv, 32'h0);

    // R8 set and clear in the same cycle
    wr(A_ARM, 32'h0001_0001);
    @(negedge clk);
    line_state = 2'b10;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = A_CLR; req_wdata = 32'h0001_0001;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd(A_FLAG, rv); chk("R8 set wins", rv, 32'h1);
    wr(A_CLR, 32'h0001_0001);

    // R5 R7 random line changes
    for (int i = 0; i < 20; i++) begin
      logic [LS_W-1:0] nv;
      nv = LS_W'($urandom);
      if (nv == line_state) nv = ~line_state;
      line_state = nv;
      wait_cycles(5);
      rd(A_FLAG, rv); chk("R5 random", rv, 32'h1);
      wr(A_CLR, 32'h0001_0001);
      rd(A_FLAG, rv); chk("R7 random clear", rv, 32'h0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule